// File: doc/BRIEF.md
# Reference Clock Failure Detector

This block watches one incoming reference clock from a fast system clock and decides whether that reference is usable. The reference is brought into the system domain through a two-stage synchronizer. Each rising edge closes one period measurement counted in system cycles. The result is compared with a frequency window of 97% to 103% of the expected period, and with a phase-hit limit of half the expected period. A 2-bit rate code selects which of four nominal reference rates is expected: 8 kHz, 1.544 MHz, 2.048 MHz or 19.44 MHz.

The outputs drive a clock-mode state machine. `fail_o` is the current verdict. `fail_pulse_o` and `ok_pulse_o` each mark one transition with a single-cycle pulse. A usable reference becomes failed in three cases:
- a run of out-of-window periods,
- a single phase hit on a megahertz rate,
- a gap with no edge for twice the expected period.

A failed reference is trusted again only after a run of consecutive in-window periods.

The expected period for each rate is a parameter. It equals the system clock frequency divided by the reference rate, rounded.

Top module: `ref_fail_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fail_o` is 1 and both pulse outputs are 0.
- R2: Rate codes are 0 = 8 kHz, 1 = 1.544 MHz, 2 = 2.048 MHz and 3 = 19.44 MHz, with expected period P taken from the matching parameter. A measured period is the number of system cycles between two successive synchronized rising edges. It is in window when floor(P*97/100) <= period <= floor(P*103/100).
- R3: The first edge after reset, after a timeout or after a rate-code change only starts a measurement. A failed reference clears `fail_o` on the GOOD_RUN-th consecutive in-window measured period (default 16).
- R4: While the reference is OK, BAD_RUN consecutive out-of-window periods (default 2) set `fail_o`.
- R9: An in-window period restarts the out-of-window run, so out-of-window periods that are not consecutive never set `fail_o`.
- R5: For rate codes 1, 2 and 3, a single period with |period - P| > floor(P/2) sets `fail_o` at once.
- R6: For rate code 0, a single period that deviates by more than floor(P/2) but is below 2P does not set `fail_o` on its own.
- R7: When 2P system cycles pass after a measured edge without another edge, `fail_o` is set.
- R8: `fail_pulse_o` is high for exactly the one cycle in which `fail_o` first reads 1 after being 0. `ok_pulse_o` is high for exactly the one cycle in which `fail_o` first reads 0 after being 1. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset, synchronous to clk_i |
| ref_i | input | 1 | Asynchronous reference clock |
| rate_sel_i | input | 2 | Nominal rate code (see R2) |
| fail_o | output | 1 | Reference currently declared failed |
| fail_pulse_o | output | 1 | One-cycle pulse on OK-to-fail |
| ok_pulse_o | output | 1 | One-cycle pulse on fail-to-OK |

## Verification
The hardest situation to reach is a loss of lock that depends on the kind of disturbance and the rate. The same large single-period deviation must fail a megahertz reference but be tolerated at 8 kHz. Likewise, alternating out-of-window periods must never accumulate into a failure. To reach these cases, the stimulus first drives a clean run until the block reports OK. It then inserts reference periods of exactly chosen lengths in system cycles, so each measured period is known, and checks the verdict after the edge that closes that period.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

    typedef enum logic [1:0] {
        RATE_8K    = 2'd0,
        RATE_1M544 = 2'd1,
        RATE_2M048 = 2'd2,
        RATE_19M44 = 2'd3
    } rate_e;

    // Phase-hit screening is only meaningful for the megahertz rates.
    function automatic logic rate_is_mhz(input logic [1:0] code);
        return code != RATE_8K;
    endfunction

endpackage

// File: rtl/refmon_sync.sv
module refmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-1:0], async_i};
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/refmon_limits.sv
module refmon_limits #(
    parameter int CW        = 16,
    parameter int PER_8K    = 12500,
    parameter int PER_1M544 = 65,
    parameter int PER_2M048 = 49,
    parameter int PER_19M44 = 5
) (
    input  logic [1:0]  rate_i,
    output logic [CW:0] nom_o,
    output logic [CW:0] lo_o,
    output logic [CW:0] hi_o,
    output logic [CW:0] half_o,
    output logic [CW:0] tmo_o
);
    localparam int W = CW + 1;
    localparam int PER [4] = '{PER_8K, PER_1M544, PER_2M048, PER_19M44};

    logic [CW:0] nom_a  [4];
    logic [CW:0] lo_a   [4];
    logic [CW:0] hi_a   [4];
    logic [CW:0] half_a [4];
    logic [CW:0] tmo_a  [4];

    for (genvar g = 0; g < 4; g++) begin : g_rate
        assign nom_a[g]  = W'(PER[g]);
        assign lo_a[g]   = W'((PER[g] * 97) / 100);
        assign hi_a[g]   = W'((PER[g] * 103) / 100);
        assign half_a[g] = W'(PER[g] / 2);
        assign tmo_a[g]  = W'(2 * PER[g]);
    end

    assign nom_o  = nom_a[rate_i];
    assign lo_o   = lo_a[rate_i];
    assign hi_o   = hi_a[rate_i];
    assign half_o = half_a[rate_i];
    assign tmo_o  = tmo_a[rate_i];
endmodule

// File: rtl/ref_fail_monitor.sv
module ref_fail_monitor
    import refmon_pkg::*;
#(
    parameter int CW        = 16,
    parameter int PER_8K    = 12500,
    parameter int PER_1M544 = 65,
    parameter int PER_2M048 = 49,
    parameter int PER_19M44 = 5,
    parameter int GOOD_RUN  = 16,
    parameter int BAD_RUN   = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ref_i,
    input  logic [1:0] rate_sel_i,
    output logic       fail_o,
    output logic       fail_pulse_o,
    output logic       ok_pulse_o
);
    localparam int GW = $clog2(GOOD_RUN + 1);
    localparam int BW = $clog2(BAD_RUN + 1);

    typedef struct packed {
        logic [1:0]    rate;
        logic          armed;
        logic [CW-1:0] cnt;
        logic [GW-1:0] good;
        logic [BW-1:0] bad;
        logic          fail;
        logic          fail_pulse;
        logic          ok_pulse;
    } mon_state_t;

    mon_state_t st_d, st_q;

    logic        rise_w;
    logic [CW:0] nom_w, lo_w, hi_w, half_w, tmo_w;
    logic [CW:0] meas_w;
    logic        in_win_w, phase_hit_w;

    refmon_sync #(.STAGES(2)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (ref_i),
        .rise_o  (rise_w)
    );

    refmon_limits #(
        .CW(CW), .PER_8K(PER_8K), .PER_1M544(PER_1M544),
        .PER_2M048(PER_2M048), .PER_19M44(PER_19M44)
    ) u_limits (
        .rate_i (st_q.rate),
        .nom_o  (nom_w),
        .lo_o   (lo_w),
        .hi_o   (hi_w),
        .half_o (half_w),
        .tmo_o  (tmo_w)
    );

    assign meas_w      = {1'b0, st_q.cnt} + 1'b1;
    assign in_win_w    = (meas_w >= lo_w) && (meas_w <= hi_w);
    assign phase_hit_w = rate_is_mhz(st_q.rate) &&
                         ((meas_w > nom_w + half_w) || (meas_w + half_w < nom_w));

    always_comb begin
        st_d            = st_q;
        st_d.rate       = rate_sel_i;
        st_d.fail_pulse = 1'b0;
        st_d.ok_pulse   = 1'b0;

        if (st_q.rate != rate_sel_i) begin
            // New rate: discard partial measurement and run counts.
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
            st_d.good  = '0;
            st_d.bad   = '0;
        end else if (rise_w) begin
            st_d.cnt = '0;
            if (!st_q.armed) begin
                st_d.armed = 1'b1;
            end else if (phase_hit_w) begin
                st_d.fail = 1'b1;
                st_d.good = '0;
                st_d.bad  = '0;
            end else if (!in_win_w) begin
                st_d.good = '0;
                if (st_q.bad >= BW'(BAD_RUN - 1)) begin
                    st_d.fail = 1'b1;
                    st_d.bad  = '0;
                end else begin
                    st_d.bad = st_q.bad + 1'b1;
                end
            end else begin
                st_d.bad = '0;
                if (st_q.fail) begin
                    if (st_q.good >= GW'(GOOD_RUN - 1)) begin
                        st_d.fail = 1'b0;
                        st_d.good = '0;
                    end else begin
                        st_d.good = st_q.good + 1'b1;
                    end
                end
            end
        end else if (st_q.armed) begin
            if (meas_w >= tmo_w) begin
                st_d.fail  = 1'b1;
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
                st_d.good  = '0;
                st_d.bad   = '0;
            end else begin
                st_d.cnt = meas_w[CW-1:0];
            end
        end

        st_d.fail_pulse = st_d.fail & ~st_q.fail;
        st_d.ok_pulse   = ~st_d.fail & st_q.fail;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.fail <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fail_o       = st_q.fail;
    assign fail_pulse_o = st_q.fail_pulse;
    assign ok_pulse_o   = st_q.ok_pulse;
endmodule

// File: rtl/refmon_checker.sv
module refmon_checker (
    input logic clk,
    input logic rst_n,
    input logic fail,
    input logic fail_pulse,
    input logic ok_pulse,
    input logic rise
);
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fail_pulse && ok_pulse)); // R8
    AST_FAIL_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> fail_pulse); // R8
    AST_OK_PULSE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail) |-> ok_pulse); // R8
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_pulse || ok_pulse) |=> !(fail_pulse || ok_pulse)); // R8
    AST_RECOVER_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail) |-> $past(rise)); // R3
endmodule

bind ref_fail_monitor refmon_checker u_chk (
    .clk        (clk_i),
    .rst_n      (rst_ni),
    .fail       (fail_o),
    .fail_pulse (fail_pulse_o),
    .ok_pulse   (ok_pulse_o),
    .rise       (rise_w)
);

// File: tb/ref_fail_monitor_bench.sv
module ref_fail_monitor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic [1:0] sel = 2'd1;
    logic       fail_o, fail_pulse_o, ok_pulse_o;

    int checks = 0;
    int errors = 0;
    int n_ok = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Expected periods: 8k=400, 1.544M=60, 2.048M=40, 19.44M=20
    ref_fail_monitor #(
        .CW(16), .PER_8K(400), .PER_1M544(60), .PER_2M048(40),
        .PER_19M44(20), .GOOD_RUN(16), .BAD_RUN(2)
    ) u_ref_fail_monitor (
        .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_in), .rate_sel_i(sel),
        .fail_o(fail_o), .fail_pulse_o(fail_pulse_o), .ok_pulse_o(ok_pulse_o)
    );

    always @(negedge clk) begin
        if (ok_pulse_o)   n_ok++;
        if (fail_pulse_o) n_fail++;
    end

    typedef struct packed {
        logic [1:0]  sel;
        logic [15:0] per;
        logic        exp_fail;
    } vec_t;

    // R2 windows: P=60 -> [58,61], P=400 -> [388,412], P=20 -> [19,20], P=40 -> [38,41]
    localparam vec_t VECS [15] = '{
        '{2'd1, 16'd60,  1'b0}, '{2'd1, 16'd58,  1'b0}, '{2'd1, 16'd57,  1'b1},
        '{2'd1, 16'd61,  1'b0}, '{2'd1, 16'd62,  1'b1}, '{2'd0, 16'd400, 1'b0},
        '{2'd0, 16'd388, 1'b0}, '{2'd0, 16'd387, 1'b1}, '{2'd0, 16'd412, 1'b0},
        '{2'd0, 16'd413, 1'b1}, '{2'd3, 16'd20,  1'b0}, '{2'd3, 16'd21,  1'b1},
        '{2'd3, 16'd19,  1'b0}, '{2'd2, 16'd40,  1'b0}, '{2'd2, 16'd42,  1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Called at a negedge; successive calls give rises exactly per cycles apart.
    task automatic send(input int per);
        ref_in = 1'b1;
        repeat (per / 2) @(negedge clk);
        ref_in = 1'b0;
        repeat (per - per / 2) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] s);
        rst_n  = 1'b0;
        ref_in = 1'b0;
        sel    = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        finish_run();
    end

    initial begin
        int base_ok, base_fail;
        @(negedge clk);
        // R1: reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 fail in reset", int'(fail_o), 1);
        chk("R1 pulses in reset", int'(fail_pulse_o | ok_pulse_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 fail after reset", int'(fail_o), 1);
        chk("R1 pulses after reset", int'(fail_pulse_o | ok_pulse_o), 0);

        // R2 window table
        for (int i = 0; i < 15; i++) begin
            do_reset(VECS[i].sel);
            base_ok = n_ok;
            repeat (20) send(int'(VECS[i].per));
            chk($sformatf("R2 vec %0d verdict", i), int'(fail_o), int'(VECS[i].exp_fail));
            chk($sformatf("R8 vec %0d ok pulses", i), n_ok - base_ok,
                VECS[i].exp_fail ? 0 : 1);
        end

        // R3: recovery needs 16 good periods after the arming edge
        do_reset(2'd1);
        base_ok = n_ok; base_fail = n_fail;
        repeat (16) send(60);
        chk("R3 still failed after 15 good", int'(fail_o), 1);
        send(60);
        chk("R3 ok after 16 good", int'(fail_o), 0);
        chk("R8 one ok pulse", n_ok - base_ok, 1);

        // R9: non-consecutive out-of-window periods
        send(64); send(60); send(64); send(60); send(60);
        chk("R9 alternating bad no fail", int'(fail_o), 0);

        // R4: two consecutive out-of-window periods
        send(62); send(63); send(60);
        chk("R4 fail after two bad", int'(fail_o), 1);
        chk("R8 one fail pulse", n_fail - base_fail, 1);

        repeat (17) send(60);
        chk("R3 recovered", int'(fail_o), 0);

        // R5: single phase hit on megahertz rate
        send(100); send(60);
        chk("R5 phase hit fails", int'(fail_o), 1);
        chk("R8 second fail pulse", n_fail - base_fail, 2);

        repeat (17) send(60);
        chk("R3 recovered again", int'(fail_o), 0);

        // R7: timeout, 2P = 120 cycles after the last edge
        send(60);
        repeat (40) @(negedge clk);
        chk("R7 before timeout", int'(fail_o), 0);
        repeat (40) @(negedge clk);
        chk("R7 after timeout", int'(fail_o), 1);

        // R6: 8 kHz tolerates a single large deviation
        do_reset(2'd0);
        repeat (17) send(400);
        chk("R6 ok at 8k", int'(fail_o), 0);
        send(700); send(400); send(400);
        chk("R6 no phase fail at 8k", int'(fail_o), 0);

        finish_run();
    end
endmodule